// File: doc/BRIEF.md
# AVLC link frame builder

This block turns one aviation link-layer frame into a serial bit stream. A frame is started with a single handshake that carries a 24-bit destination address, a 24-bit source address, a control-byte choice and two mode bits. The information field then arrives one byte at a time on a valid/ready stream. The block computes the 16-bit frame check while the body goes out. It inserts a zero after every run of five ones and puts a flag byte on each side of the frame.

The addresses go out most significant byte first. A control byte of 0x13 is used unless the caller supplies its own. When the caller asks for the message-service marker, the three bytes FF FF 01 are placed ahead of the information bytes. The serial output uses its own valid/ready pair, so a slow consumer can hold the stream without losing bits. If the information bytes arrive late, the stream pauses until they are available.

Top module: `avlc_framer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `frm_ready` is 1 and `bit_valid` is 0.
- R2: Every frame begins with the flag byte 0x7E and ends with the flag byte 0x7E, each sent LSB first. The run of six ones inside a flag is never broken by an inserted zero.
- R3: The body is sent in this order: the destination address as 3 bytes, most significant byte first; then the source address in the same way; then one control byte; then the information bytes in arrival order. Each byte is sent LSB first.
- R4: When `ctrl_use_own` = 0 the control byte is 0x13. When `ctrl_use_own` = 1 it is `ctrl_byte`.
- R5: When `acars_mark` = 1, the bytes 0xFF, 0xFF, 0x01 are sent, in that order, between the control byte and the first information byte.
- R6: When `no_info` = 1, no information byte is taken. The body then ends after the control byte, or after the marker if one is sent. The body is therefore never shorter than 7 bytes.
- R7: After the body comes a 16-bit check: CRC-16 with reflected polynomial 0x8408, initial value 0xFFFF, computed over the body bits in transmit order, and complemented. It is sent low byte first, each byte LSB first.
- R8: Over the body and the check, a 0 is inserted after every five consecutive 1s, and the count of ones restarts after each inserted 0. Five 1s at the very end of the check also get an inserted 0 before the closing flag.
- R9: While `bit_valid` = 1 and `bit_ready` = 0, `bit_valid` stays 1 and `bit_data` does not change. Gaps on `info_valid` pause the stream without dropping or repeating any bit.
- R10: A `frm_start` raised while `frm_ready` = 0 is ignored. The frame in progress keeps its latched addresses, control and modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_start | input | 1 | Request a new frame; accepted only when `frm_ready` = 1 |
| frm_ready | output | 1 | No frame in progress |
| dst_addr | input | 24 | Destination address, latched at start |
| src_addr | input | 24 | Source address, latched at start |
| ctrl_use_own | input | 1 | 1 selects `ctrl_byte`, 0 selects 0x13 |
| ctrl_byte | input | 8 | Caller control byte |
| acars_mark | input | 1 | 1 inserts FF FF 01 ahead of the information bytes |
| no_info | input | 1 | 1 means the frame carries no information bytes |
| info_valid | input | 1 | Information byte available |
| info_data | input | 8 | Information byte |
| info_last | input | 1 | This information byte is the last one |
| info_ready | output | 1 | Information byte taken this cycle |
| bit_valid | output | 1 | Serial bit available |
| bit_data | output | 1 | Serial bit |
| bit_ready | input | 1 | Consumer takes the serial bit this cycle |

## Verification
Some properties are checked by assertions on every cycle:
- the output stays silent when idle;
- a held bit stays stable under back-pressure;
- the information stream is never taken outside a frame;
- the field sequencer runs dry after the last byte;
- the framing phases move in order;
- no sixth consecutive one appears in the body or check.

Other properties only the bench scenarios can show, by comparing every emitted bit with a stream built from the frame description:
- the exact byte order and bit order;
- the control byte that is chosen;
- where the marker is placed;
- the check value;
- that stuffing happens exactly where it should;
- that a start pulse during a busy frame leaves that frame unchanged.

// File: rtl/avlc_pkg.sv
// Shared constants and types for the link frame builder.
// Assumes 8-bit bytes and a reflected 16-bit frame check.
package avlc_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 3;
    localparam int MARK_LEN   = 3;
    localparam int STUFF_RUN  = 5;
    localparam int FCS_W      = 16;
    localparam int ONES_W     = $clog2(STUFF_RUN + 1);
    localparam int CNT_W      = $clog2(FCS_W);

    localparam logic [BYTE_W-1:0] CTRL_DFLT = 8'h13;
    localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
    localparam logic [FCS_W-1:0]  CRC_POLY  = 16'h8408;
    localparam logic [FCS_W-1:0]  CRC_INIT  = 16'hFFFF;

    typedef enum logic [2:0] {
        PH_IDLE, PH_OPEN, PH_BODY, PH_FCS, PH_CLOSE
    } phase_t;

    typedef enum logic [1:0] {
        CRC_HOLD, CRC_CLR, CRC_UPD, CRC_SHIFT
    } crc_mode_t;

    // Marker byte at a given position: FF FF 01.
    function automatic logic [BYTE_W-1:0] mark_byte(input int idx);
        return (idx == MARK_LEN - 1) ? 8'h01 : 8'hFF;
    endfunction
endpackage

// File: rtl/avlc_field_seq.sv
// Field sequencer: presents the frame body one byte at a time. Order is
// destination (MSB byte first), source, control, optional marker, then
// information bytes from the caller stream. Fields are latched on load and
// held until the next load. Assumes load only arrives while idle.
module avlc_field_seq
    import avlc_pkg::*;
#(
    parameter int NADDR = ADDR_BYTES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [8*NADDR-1:0]      dst_in,
    input  logic [8*NADDR-1:0]      src_in,
    input  logic                    own_ctrl,
    input  logic [BYTE_W-1:0]       ctrl_in,
    input  logic                    mark_in,
    input  logic                    noinfo_in,
    input  logic                    info_valid,
    input  logic [BYTE_W-1:0]       info_data,
    input  logic                    info_last,
    output logic                    info_ready,
    input  logic                    take,
    output logic                    byte_valid,
    output logic [BYTE_W-1:0]       byte_data,
    output logic                    byte_last
);
    localparam int AW       = 8 * NADDR;
    localparam int HDR_LEN  = 2 * NADDR + 1;
    localparam int MARK_END = HDR_LEN + MARK_LEN;
    localparam int PW       = $clog2(MARK_END + 2);
    localparam logic [PW-1:0] P_CTRL  = PW'(HDR_LEN - 1);
    localparam logic [PW-1:0] P_MARK0 = PW'(HDR_LEN);
    localparam logic [PW-1:0] P_MLAST = PW'(MARK_END - 1);
    localparam logic [PW-1:0] P_INFO  = PW'(MARK_END);
    localparam logic [PW-1:0] P_DONE  = PW'(MARK_END + 1);

    logic [AW-1:0]     dst_q, src_q;
    logic [BYTE_W-1:0] ctrl_q;
    logic              mark_q, noinfo_q;
    logic [PW-1:0]     ptr, ptr_nx;
    logic [BYTE_W-1:0] hdr [HDR_LEN];

    // Header byte table built from the latched addresses and control.
    for (genvar g = 0; g < NADDR; g++) begin : g_addr
        assign hdr[g]         = dst_q[AW-1-8*g -: 8];
        assign hdr[NADDR + g] = src_q[AW-1-8*g -: 8];
    end
    assign hdr[HDR_LEN-1] = ctrl_q;

    // Next field position after the current byte is taken.
    always_comb begin
        if (ptr == P_CTRL)
            ptr_nx = mark_q ? P_MARK0 : (noinfo_q ? P_DONE : P_INFO);
        else if (ptr == P_MLAST)
            ptr_nx = noinfo_q ? P_DONE : P_INFO;
        else if (ptr == P_INFO)
            ptr_nx = info_last ? P_DONE : P_INFO;
        else
            ptr_nx = ptr + PW'(1);
    end

    // Byte presented to the serializer at the current position.
    always_comb begin
        if (ptr < P_MARK0) begin
            byte_valid = 1'b1;
            byte_data  = hdr[ptr];
        end else if (ptr < P_INFO) begin
            byte_valid = 1'b1;
            byte_data  = mark_byte(int'(ptr) - HDR_LEN);
        end else if (ptr == P_INFO) begin
            byte_valid = info_valid;
            byte_data  = info_data;
        end else begin
            byte_valid = 1'b0;
            byte_data  = '0;
        end
        byte_last = (ptr == P_CTRL && !mark_q && noinfo_q) ||
                    (ptr == P_MLAST && noinfo_q) ||
                    (ptr == P_INFO && info_last);
    end

    assign info_ready = take && (ptr == P_INFO);

    // Latch frame fields on load and step through the body on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= P_DONE;
            dst_q    <= '0;
            src_q    <= '0;
            ctrl_q   <= CTRL_DFLT;
            mark_q   <= 1'b0;
            noinfo_q <= 1'b0;
        end else if (load) begin
            ptr      <= '0;
            dst_q    <= dst_in;
            src_q    <= src_in;
            ctrl_q   <= own_ctrl ? ctrl_in : CTRL_DFLT;
            mark_q   <= mark_in;
            noinfo_q <= noinfo_in;
        end else if (take) begin
            ptr <= ptr_nx;
        end
    end

    // R6
    last_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && byte_last && !load) |=> !byte_valid);
endmodule

// File: rtl/avlc_fcs16.sv
// Frame check register. Clears to all ones, folds in one body bit per
// update (reflected polynomial), and shifts right plainly while the
// check bits are sent out from bit 0.
module avlc_fcs16
    import avlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  crc_mode_t        mode,
    input  logic             bit_in,
    output logic [FCS_W-1:0] crc_q
);
    // Update the check register according to the requested mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_INIT;
        end else begin
            case (mode)
                CRC_CLR:   crc_q <= CRC_INIT;
                CRC_UPD:   crc_q <= (crc_q >> 1) ^ ((crc_q[0] ^ bit_in) ? CRC_POLY : '0);
                CRC_SHIFT: crc_q <= crc_q >> 1;
                default:   crc_q <= crc_q;
            endcase
        end
    end
endmodule

// File: rtl/avlc_bit_ser.sv
// Bit serializer: sends the opening flag, the body bytes LSB first, the
// complemented check LSB first, then the closing flag. It inserts a zero
// after five ones in the body and check. The next body byte is fetched
// on the last bit of the current byte, so a steady source leaves no gaps.
// Assumes go only arrives while idle.
module avlc_bit_ser
    import avlc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    output logic              idle,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_last,
    output logic              byte_take,
    output crc_mode_t         crc_mode,
    output logic              crc_bit,
    input  logic [FCS_W-1:0]  crc_q,
    output logic              bit_valid,
    output logic              bit_data,
    input  logic              bit_ready
);
    localparam logic [CNT_W-1:0] LAST_BYTE_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] LAST_FCS_BIT  = CNT_W'(FCS_W - 1);

    phase_t            ph;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic              loaded, cur_last;
    logic [ONES_W-1:0] ones;
    logic              stuff_now, fire, flag_bit, byte_end;

    assign idle      = (ph == PH_IDLE);
    assign stuff_now = (ph == PH_BODY || ph == PH_FCS || ph == PH_CLOSE) &&
                       (ones == ONES_W'(STUFF_RUN));
    assign flag_bit  = FLAG_BYTE[cnt[2:0]];

    // Output bit selection for the current phase.
    always_comb begin
        bit_valid = 1'b0;
        bit_data  = 1'b0;
        case (ph)
            PH_OPEN:  begin bit_valid = 1'b1; bit_data = flag_bit; end
            PH_BODY:  begin bit_valid = stuff_now || loaded; bit_data = !stuff_now && sh[0]; end
            PH_FCS:   begin bit_valid = 1'b1; bit_data = !stuff_now && !crc_q[0]; end
            PH_CLOSE: begin bit_valid = 1'b1; bit_data = !stuff_now && flag_bit; end
            default:  begin bit_valid = 1'b0; bit_data = 1'b0; end
        endcase
    end

    assign fire     = bit_valid && bit_ready;
    assign byte_end = fire && !stuff_now && (cnt == LAST_BYTE_BIT);
    assign crc_bit  = sh[0];

    // Fetch the next body byte at the end of the opening flag, when empty,
    // or on the last bit of a byte that is not the final one.
    assign byte_take = byte_valid &&
        ((ph == PH_OPEN && fire && cnt == LAST_BYTE_BIT) ||
         (ph == PH_BODY && (!loaded || (byte_end && !cur_last))));

    // Check register control: clear at start, fold body bits, shift out.
    always_comb begin
        if (go && idle)
            crc_mode = CRC_CLR;
        else if (ph == PH_BODY && fire && !stuff_now)
            crc_mode = CRC_UPD;
        else if (ph == PH_FCS && fire && !stuff_now)
            crc_mode = CRC_SHIFT;
        else
            crc_mode = CRC_HOLD;
    end

    // Phase, bit counter, ones run and byte register sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            sh       <= '0;
            loaded   <= 1'b0;
            cur_last <= 1'b0;
            ones     <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (go) begin
                        ph     <= PH_OPEN;
                        cnt    <= '0;
                        ones   <= '0;
                        loaded <= 1'b0;
                    end
                end
                PH_OPEN: begin
                    if (fire) begin
                        if (cnt == LAST_BYTE_BIT) begin
                            ph  <= PH_BODY;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                PH_BODY: begin
                    if (fire && stuff_now) begin
                        ones <= '0;
                    end else if (fire) begin
                        ones <= sh[0] ? ones + ONES_W'(1) : '0;
                        sh   <= sh >> 1;
                        if (cnt == LAST_BYTE_BIT) begin
                            cnt    <= '0;
                            loaded <= 1'b0;
                            if (cur_last)
                                ph <= PH_FCS;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                PH_FCS: begin
                    if (fire && stuff_now) begin
                        ones <= '0;
                    end else if (fire) begin
                        ones <= !crc_q[0] ? ones + ONES_W'(1) : '0;
                        if (cnt == LAST_FCS_BIT) begin
                            ph  <= PH_CLOSE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                PH_CLOSE: begin
                    if (fire && stuff_now) begin
                        ones <= '0;
                    end else if (fire) begin
                        ones <= '0;
                        if (cnt == LAST_BYTE_BIT) begin
                            ph  <= PH_IDLE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                default: ph <= PH_IDLE;
            endcase
            if (byte_take) begin
                sh       <= byte_data;
                cur_last <= byte_last;
                loaded   <= 1'b1;
            end
        end
    end

    // Run of ones actually emitted, kept apart from the stuffing counter.
    logic [2:0] out_run;
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_run <= '0;
        else if (fire)
            out_run <= bit_data ? ((out_run == 3'd7) ? out_run : out_run + 3'd1) : '0;
    end

    // R8
    no_sixth_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph == PH_BODY || ph == PH_FCS) && fire && out_run == 3'd5) |-> !bit_data);

    // R2
    open_leads_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_OPEN) |=> (ph == PH_OPEN || ph == PH_BODY));

    // R7
    fcs_leads_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_FCS) |=> (ph == PH_FCS || ph == PH_CLOSE));
endmodule

// File: rtl/avlc_framer.sv
// Top of the link frame builder. It accepts a frame request while idle,
// latches the header fields, and streams the stuffed, flag-delimited
// frame with its check on a valid/ready bit output. Information bytes are
// pulled from a valid/ready byte stream as the serializer needs them.
module avlc_framer
    import avlc_pkg::*;
#(
    parameter int NADDR = ADDR_BYTES,
    localparam int AW   = 8 * NADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_start,
    output logic              frm_ready,
    input  logic [AW-1:0]     dst_addr,
    input  logic [AW-1:0]     src_addr,
    input  logic              ctrl_use_own,
    input  logic [BYTE_W-1:0] ctrl_byte,
    input  logic              acars_mark,
    input  logic              no_info,
    input  logic              info_valid,
    input  logic [BYTE_W-1:0] info_data,
    input  logic              info_last,
    output logic              info_ready,
    output logic              bit_valid,
    output logic              bit_data,
    input  logic              bit_ready
);
    logic              idle, go, take, bv, bl, cbit;
    logic [BYTE_W-1:0] bd;
    logic [FCS_W-1:0]  crc;
    crc_mode_t         cmode;

    assign frm_ready = idle;
    assign go        = frm_start && idle;

    avlc_field_seq #(.NADDR(NADDR)) u_seq (
        .clk(clk), .rst_n(rst_n), .load(go),
        .dst_in(dst_addr), .src_in(src_addr),
        .own_ctrl(ctrl_use_own), .ctrl_in(ctrl_byte),
        .mark_in(acars_mark), .noinfo_in(no_info),
        .info_valid(info_valid), .info_data(info_data), .info_last(info_last),
        .info_ready(info_ready), .take(take),
        .byte_valid(bv), .byte_data(bd), .byte_last(bl)
    );

    avlc_fcs16 u_fcs (
        .clk(clk), .rst_n(rst_n), .mode(cmode), .bit_in(cbit), .crc_q(crc)
    );

    avlc_bit_ser u_ser (
        .clk(clk), .rst_n(rst_n), .go(go), .idle(idle),
        .byte_valid(bv), .byte_data(bd), .byte_last(bl), .byte_take(take),
        .crc_mode(cmode), .crc_bit(cbit), .crc_q(crc),
        .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ready |-> !bit_valid);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_data)));

    // R10
    info_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        info_ready |-> !frm_ready);
endmodule

// File: tb/tb_avlc_framer.sv
// Scoreboard bench: the driver builds the expected bit stream for each
// frame and queues it; a monitor compares every transferred bit.
module tb_avlc_framer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_start = 1'b0, frm_ready;
    logic [23:0] dst_addr = '0, src_addr = '0;
    logic        ctrl_use_own = 1'b0;
    logic [7:0]  ctrl_byte = '0;
    logic        acars_mark = 1'b0, no_info = 1'b0;
    logic        info_valid = 1'b0, info_last = 1'b0, info_ready;
    logic [7:0]  info_data = '0;
    logic        bit_valid, bit_data, bit_ready = 1'b1;

    int checks = 0, failures = 0;
    int frame_err = 0, stab_err = 0, extra_err = 0;
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic expq[$];
    logic prev_hold = 1'b0, prev_bit = 1'b0;

    always #10 clk = ~clk;

    avlc_framer dut (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_ready(frm_ready),
        .dst_addr(dst_addr), .src_addr(src_addr), .ctrl_use_own(ctrl_use_own),
        .ctrl_byte(ctrl_byte), .acars_mark(acars_mark), .no_info(no_info),
        .info_valid(info_valid), .info_data(info_data), .info_last(info_last),
        .info_ready(info_ready), .bit_valid(bit_valid), .bit_data(bit_data),
        .bit_ready(bit_ready)
    );

    // Consumer ready pattern, changed on the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (rdy_mode)
                0:       bit_ready = 1'b1;
                1:       bit_ready = lfsr[0] | lfsr[2];
                default: bit_ready = lfsr[0] & lfsr[1];
            endcase
        end
    end

    // Monitor: compares transferred bits and watches held-bit stability.
    initial begin
        logic e;
        forever begin
            @(negedge clk);
            #5;
            if (rst_n) begin
                if (prev_hold && !(bit_valid && bit_data == prev_bit)) stab_err++;
                prev_hold = bit_valid && !bit_ready;
                prev_bit  = bit_data;
                if (bit_valid && bit_ready) begin
                    if (expq.size() == 0) begin
                        extra_err++;
                    end else begin
                        e = expq.pop_front();
                        if (e !== bit_data) begin
                            if (frame_err == 0)
                                $display("  first mismatch: got %b want %b (%0d bits left)",
                                         bit_data, e, expq.size());
                            frame_err++;
                        end
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected stream: flags, body and check LSB first, stuffing per R8.
    function automatic void push_frame(input logic [7:0] body[$]);
        logic [15:0] crc = 16'hFFFF;
        logic [15:0] fcs;
        logic        dbits[$];
        int          ones = 0;
        foreach (body[i]) begin
            for (int b = 0; b < 8; b++) begin
                dbits.push_back(body[i][b]);
                crc = (crc >> 1) ^ ((crc[0] ^ body[i][b]) ? 16'h8408 : 16'h0000);
            end
        end
        fcs = ~crc;
        for (int b = 0; b < 16; b++) dbits.push_back(fcs[b]);
        for (int b = 0; b < 8; b++) expq.push_back(b != 0 && b != 7);
        foreach (dbits[i]) begin
            if (ones == 5) begin
                expq.push_back(1'b0);
                ones = 0;
            end
            expq.push_back(dbits[i]);
            ones = dbits[i] ? ones + 1 : 0;
        end
        if (ones == 5) expq.push_back(1'b0);
        for (int b = 0; b < 8; b++) expq.push_back(b != 0 && b != 7);
    endfunction

    task automatic run_frame(input logic [23:0] d, input logic [23:0] s, input logic own,
                             input logic [7:0] c, input logic mark, input logic [7:0] info[$],
                             input int gap, input bit poke, input string tag);
        logic [7:0] body[$];
        for (int k = 2; k >= 0; k--) body.push_back(d[8*k +: 8]);
        for (int k = 2; k >= 0; k--) body.push_back(s[8*k +: 8]);
        body.push_back(own ? c : 8'h13);
        if (mark) begin
            body.push_back(8'hFF);
            body.push_back(8'hFF);
            body.push_back(8'h01);
        end
        foreach (info[i]) body.push_back(info[i]);
        do begin @(negedge clk); #7; end while (!frm_ready);
        @(negedge clk);
        frame_err = 0;
        push_frame(body);
        dst_addr = d; src_addr = s; ctrl_use_own = own; ctrl_byte = c;
        acars_mark = mark; no_info = (info.size() == 0);
        frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            dst_addr = ~d; src_addr = ~s; ctrl_use_own = 1'b1; ctrl_byte = 8'h00;
            acars_mark = ~mark; no_info = 1'b1;
            frm_start = 1'b1;
            @(negedge clk);
            frm_start = 1'b0;
        end
        foreach (info[i]) begin
            @(negedge clk);
            info_valid = 1'b0;
            repeat (gap) @(negedge clk);
            info_valid = 1'b1;
            info_data  = info[i];
            info_last  = (i == info.size() - 1);
            forever begin
                #6;
                if (info_ready) break;
                @(negedge clk);
            end
        end
        @(negedge clk);
        info_valid = 1'b0;
        info_last  = 1'b0;
        do begin @(negedge clk); #7; end while (!(expq.size() == 0 && frm_ready));
        check(frame_err == 0, tag, frame_err, 0);
    endtask

    initial begin
        logic [7:0] none[$];
        logic [7:0] longi[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #7;
        check(frm_ready == 1'b1, "R1 frm_ready after reset", int'(frm_ready), 1);
        check(bit_valid == 1'b0, "R1 bit_valid after reset", int'(bit_valid), 0);

        run_frame(24'hABCDEF, 24'h123456, 1'b0, 8'h00, 1'b0, '{8'h7E, 8'h7E, 8'hFF},
                  0, 1'b0, "R2 R3 R4 R7 R8 default control, flag-like info");
        rdy_mode = 1;
        run_frame(24'h0A0B0C, 24'hC0FFEE, 1'b1, 8'hA5, 1'b1,
                  '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35},
                  0, 1'b0, "R4 R5 R9 own control with marker");
        run_frame(24'h000001, 24'h800000, 1'b0, 8'h00, 1'b0, none,
                  0, 1'b0, "R6 seven-byte body");
        run_frame(24'h111111, 24'h222222, 1'b1, 8'h3C, 1'b1, none,
                  0, 1'b0, "R5 R6 marker only");
        rdy_mode = 0;
        run_frame(24'hFFFFFF, 24'hFFFFFF, 1'b1, 8'hFF, 1'b0, '{8'hFF, 8'hFF},
                  0, 1'b0, "R8 all ones stuffing");
        rdy_mode = 2;
        run_frame(24'h5A5A5A, 24'hA5A5A5, 1'b0, 8'h00, 1'b1, '{8'h1F, 8'hF8, 8'h00},
                  3, 1'b0, "R9 info gaps and slow consumer");
        rdy_mode = 1;
        run_frame(24'h314159, 24'h271828, 1'b1, 8'h77, 1'b0, '{8'hC3, 8'h3C},
                  1, 1'b1, "R10 start ignored while busy");
        for (int k = 0; k < 20; k++) longi.push_back(8'(k * 37 + 5));
        run_frame(24'h9ABCDE, 24'h13579B, 1'b0, 8'h00, 1'b1, longi,
                  0, 1'b0, "R3 R7 twenty information bytes");
        rdy_mode = 0;

        check(stab_err == 0, "R9 held bit stable", stab_err, 0);
        check(extra_err == 0, "R3 no bits beyond expected frames", extra_err, 0);
        #7;
        check(bit_valid == 1'b0, "R1 quiet after last frame", int'(bit_valid), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule